// File: doc/BRIEF.md
# Processor exception entry and return controller

This block owns the exception-state registers of a 32-bit system coprocessor: the Status word (boot-vector select, exception level, error level), the Cause word (delay-slot flag, coprocessor-unusable field, exception code, interrupt-vector select), the exception return address, the error return address and the exception base. When the pipeline raises an exception request, the block saves the return point, updates Status and Cause, and computes the handler address. When the pipeline signals an exception return, the block picks the right saved address, clears the matching level bit and tells the pipeline which instruction-set mode to resume in.

Every event is sampled on a rising clock edge. The pipeline redirect is a registered one-cycle pulse in the following cycle. It carries the target PC and the new compressed-ISA mode. An exception return also raises a pulse that clears the load-linked reservation. Software reads the five registers through a small register-select port and writes them one at a time. Decoding instructions, evaluating interrupts and holding TLB contents are left to other blocks.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, Status reads 0x00400000 (only the boot-vector bit 22 set), Cause reads 0, the exception base reads 0x80000000, and redirect, ll_clear and isa_mode_out are 0.
- R2: On an exception taken while Status bit 1 (exception level) is clear, the return address register becomes the PC OR'd with the compressed-ISA flag in bit 0, and Cause bit 31 becomes the delay-slot flag.
- R3: On an exception taken while Status bit 1 is already set, the return address register and Cause bit 31 keep their values.
- R4: On every exception, Cause bits [6:2] take the request code and all other Cause bits keep their values, except bit 31 as given in R2 and bit 28 as given in R9.
- R5: On every exception, Status bit 1 is set, Status bit 2 (error level) is cleared, the other Status bits keep their values, and isa_mode_out becomes 0.
- R6: The handler address is the base plus 0x180, where the base is 0xBFC00200 when Status bit 22 is 1 and the exception-base register when it is 0.
- R7: Only when Status bit 1 was clear before the exception: codes 2 and 3 (TLB load and store miss) go to the base plus 0x000, and code 0 (interrupt) goes to the base plus 0x200 when Cause bit 23 is set. Otherwise the address in R6 is used.
- R8: An exception return with Status bit 2 set clears bit 2 and targets the error return address. Without it, the return clears bit 1 and targets the return address. Either way, redirect_pc is the target with bit 0 forced to 0, isa_mode_out is the target's bit 0, and ll_clear pulses together with redirect.
- R9: A missing-FPU request raises code 11 and sets Cause bit 28, with all other effects of an exception.
- R10: redirect is high for exactly the cycle after each accepted event. When an exception request and an exception return arrive in the same cycle, the exception is taken, the return has no effect and ll_clear stays 0. An exception request also wins over a missing-FPU request.
- R11: Register select 0 to 4 maps to Status, Cause, return address, error return address and exception base. Any other select reads 0. A write replaces the whole register, but a write in the same cycle as an exception or a return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request strobe |
| exc_code | input | 5 | Exception code for exc_req |
| fpu_req | input | 1 | Floating-point instruction with no FPU present |
| exc_in_delay | input | 1 | Faulting instruction sits in a delay slot |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_isa | input | 1 | Compressed-ISA mode at the fault |
| eret | input | 1 | Exception return strobe |
| csr_we | input | 1 | Software register write enable |
| csr_sel | input | 3 | Software register select |
| csr_wdata | input | 32 | Software write data |
| csr_rdata | output | 32 | Software read data (combinational) |
| redirect | output | 1 | One-cycle pipeline redirect pulse |
| redirect_pc | output | 32 | Redirect target PC |
| isa_mode_out | output | 1 | ISA mode to resume in |
| ll_clear | output | 1 | Clear the load-linked reservation |

## Verification
An exception request can arrive together with an exception return, and either event can coincide with a software write. The bench drives these pairs on purpose, both in directed cases and in a random mix. It judges each one by reading all five registers afterwards and comparing the redirect target and ll_clear against a bench model in which the exception takes precedence and the write is dropped. Nested exceptions are provoked by taking a second exception before any return, or by writing Status with bit 1 set. The check is that the saved address and the delay-slot flag do not move and that the vector offsets do not apply.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
    localparam int XLEN = 32;
    localparam int CODE_W = 5;

    localparam int ST_EXL = 1;
    localparam int ST_ERL = 2;
    localparam int ST_BEV = 22;
    localparam int CA_BD = 31;
    localparam int CA_CE = 28;
    localparam int CA_IV = 23;
    localparam int CA_CODE_LO = 2;
    localparam int CA_CODE_HI = 6;

    localparam logic [CODE_W-1:0] CODE_INT = 5'd0;
    localparam logic [CODE_W-1:0] CODE_TLBL = 5'd2;
    localparam logic [CODE_W-1:0] CODE_TLBS = 5'd3;
    localparam logic [CODE_W-1:0] CODE_CPU = 5'd11;

    localparam logic [XLEN-1:0] OFS_REFILL = 32'h000;
    localparam logic [XLEN-1:0] OFS_GENERAL = 32'h180;
    localparam logic [XLEN-1:0] OFS_IRQ = 32'h200;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_CAUSE = 3'd1,
        SEL_EPC = 3'd2,
        SEL_ERRPC = 3'd3,
        SEL_EBASE = 3'd4
    } csr_sel_e;

    typedef struct packed {
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] errpc;
        logic [XLEN-1:0] ebase;
        logic [XLEN-1:0] target;
        logic            redirect;
        logic            isa;
        logic            llclr;
    } ctrl_state_t;
endpackage

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_ctrl_pkg::*;
#(
    parameter logic [XLEN-1:0] BOOT_BASE = 32'hBFC00200
) (
    input  logic              bev,
    input  logic              exl,
    input  logic              iv,
    input  logic [XLEN-1:0]   ebase,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   vector
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base = bev ? BOOT_BASE : ebase;
        offset = OFS_GENERAL;
        if (!exl) begin
            if (code == CODE_TLBL || code == CODE_TLBS) begin
                offset = OFS_REFILL;
            end else if (code == CODE_INT && iv) begin
                offset = OFS_IRQ;
            end
        end
        vector = base + offset;
    end
endmodule

// File: rtl/exc_cause_update.sv
module exc_cause_update
    import exc_ctrl_pkg::*;
(
    input  logic [XLEN-1:0]   cause_in,
    input  logic              exl,
    input  logic              in_delay,
    input  logic              set_ce,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   cause_out
);
    always_comb begin
        cause_out = cause_in;
        if (!exl) begin
            cause_out[CA_BD] = in_delay;
        end
        if (set_ce) begin
            cause_out[CA_CE] = 1'b1;
        end
        cause_out[CA_CODE_HI:CA_CODE_LO] = code;
    end
endmodule

// File: rtl/exc_return_sel.sv
module exc_return_sel
    import exc_ctrl_pkg::*;
(
    input  logic [XLEN-1:0] status_in,
    input  logic [XLEN-1:0] epc,
    input  logic [XLEN-1:0] errpc,
    output logic [XLEN-1:0] status_out,
    output logic [XLEN-1:0] target,
    output logic            isa
);
    logic [XLEN-1:0] raw;

    always_comb begin
        status_out = status_in;
        if (status_in[ST_ERL]) begin
            raw = errpc;
            status_out[ST_ERL] = 1'b0;
        end else begin
            raw = epc;
            status_out[ST_EXL] = 1'b0;
        end
        isa = raw[0];
        target = {raw[XLEN-1:1], 1'b0};
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_ctrl_pkg::*;
#(
    parameter logic [XLEN-1:0] BOOT_BASE = 32'hBFC00200,
    parameter logic [XLEN-1:0] RESET_EBASE = 32'h80000000,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              fpu_req,
    input  logic              exc_in_delay,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic              exc_isa,
    input  logic              eret,
    input  logic              csr_we,
    input  logic [SEL_W-1:0]  csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              redirect,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              isa_mode_out,
    output logic              ll_clear
);
    localparam logic [XLEN-1:0] RESET_STATUS = XLEN'(1) << ST_BEV;

    ctrl_state_t state_d, state_q;

    logic              take_exc;
    logic              set_ce;
    logic [CODE_W-1:0] code_eff;
    logic [XLEN-1:0]   vector_w;
    logic [XLEN-1:0]   cause_w;
    logic [XLEN-1:0]   ret_status_w;
    logic [XLEN-1:0]   ret_target_w;
    logic              ret_isa_w;
    logic [XLEN-1:0]   status_cur;
    logic [XLEN-1:0]   cause_cur;
    logic [XLEN-1:0]   epc_cur;

    assign take_exc = exc_req | fpu_req;
    assign set_ce = fpu_req & ~exc_req;
    assign code_eff = exc_req ? exc_code : CODE_CPU;

    exc_vector_gen #(.BOOT_BASE(BOOT_BASE)) u_vec (
        .bev    (state_q.status[ST_BEV]),
        .exl    (state_q.status[ST_EXL]),
        .iv     (state_q.cause[CA_IV]),
        .ebase  (state_q.ebase),
        .code   (code_eff),
        .vector (vector_w)
    );

    exc_cause_update u_cause (
        .cause_in  (state_q.cause),
        .exl       (state_q.status[ST_EXL]),
        .in_delay  (exc_in_delay),
        .set_ce    (set_ce),
        .code      (code_eff),
        .cause_out (cause_w)
    );

    exc_return_sel u_ret (
        .status_in  (state_q.status),
        .epc        (state_q.epc),
        .errpc      (state_q.errpc),
        .status_out (ret_status_w),
        .target     (ret_target_w),
        .isa        (ret_isa_w)
    );

    always_comb begin
        state_d = state_q;
        state_d.redirect = 1'b0;
        state_d.llclr = 1'b0;
        if (take_exc) begin
            if (!state_q.status[ST_EXL]) begin
                state_d.epc = exc_pc | {{(XLEN-1){1'b0}}, exc_isa};
            end
            state_d.cause = cause_w;
            state_d.status[ST_EXL] = 1'b1;
            state_d.status[ST_ERL] = 1'b0;
            state_d.redirect = 1'b1;
            state_d.target = vector_w;
            state_d.isa = 1'b0;
        end else if (eret) begin
            state_d.status = ret_status_w;
            state_d.redirect = 1'b1;
            state_d.target = ret_target_w;
            state_d.isa = ret_isa_w;
            state_d.llclr = 1'b1;
        end else if (csr_we) begin
            case (csr_sel_e'(csr_sel))
                SEL_STATUS: state_d.status = csr_wdata;
                SEL_CAUSE:  state_d.cause = csr_wdata;
                SEL_EPC:    state_d.epc = csr_wdata;
                SEL_ERRPC:  state_d.errpc = csr_wdata;
                SEL_EBASE:  state_d.ebase = csr_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            state_q.status <= RESET_STATUS;
            state_q.ebase <= RESET_EBASE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (csr_sel_e'(csr_sel))
            SEL_STATUS: csr_rdata = state_q.status;
            SEL_CAUSE:  csr_rdata = state_q.cause;
            SEL_EPC:    csr_rdata = state_q.epc;
            SEL_ERRPC:  csr_rdata = state_q.errpc;
            SEL_EBASE:  csr_rdata = state_q.ebase;
            default:    csr_rdata = '0;
        endcase
    end

    assign status_cur = state_q.status;
    assign cause_cur = state_q.cause;
    assign epc_cur = state_q.epc;
    assign redirect = state_q.redirect;
    assign redirect_pc = state_q.target;
    assign isa_mode_out = state_q.isa;
    assign ll_clear = state_q.llclr;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              exc_req,
    input logic              fpu_req,
    input logic [CODE_W-1:0] exc_code,
    input logic              eret,
    input logic              redirect,
    input logic              ll_clear,
    input logic              isa_mode_out,
    input logic [XLEN-1:0]   redirect_pc,
    input logic [XLEN-1:0]   status_cur,
    input logic [XLEN-1:0]   cause_cur,
    input logic [XLEN-1:0]   epc_cur
);
    AST_EVENT_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || fpu_req || eret) |=> redirect); // R10
    AST_QUIET_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_req || fpu_req || eret) |=> !redirect); // R10
    AST_ENTRY_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || fpu_req) |=> (status_cur[ST_EXL] && !status_cur[ST_ERL] && !isa_mode_out)); // R5
    AST_ENTRY_NO_LLCLR: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req || fpu_req) |=> !ll_clear); // R10
    AST_LLCLR_WITH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        ll_clear |-> (redirect && !redirect_pc[0])); // R8
    AST_NESTED_EPC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((exc_req || fpu_req) && status_cur[ST_EXL]) |=> $stable(epc_cur)); // R3
    AST_NESTED_BD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((exc_req || fpu_req) && status_cur[ST_EXL]) |=> $stable(cause_cur[CA_BD])); // R3
    AST_CODE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (cause_cur[CA_CODE_HI:CA_CODE_LO] == $past(exc_code))); // R4
    AST_FPU_CE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (fpu_req && !exc_req) |=> (cause_cur[CA_CE] && cause_cur[CA_CODE_HI:CA_CODE_LO] == CODE_CPU)); // R9
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_req      (exc_req),
    .fpu_req      (fpu_req),
    .exc_code     (exc_code),
    .eret         (eret),
    .redirect     (redirect),
    .ll_clear     (ll_clear),
    .isa_mode_out (isa_mode_out),
    .redirect_pc  (redirect_pc),
    .status_cur   (status_cur),
    .cause_cur    (cause_cur),
    .epc_cur      (epc_cur)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        fpu_req = 1'b0;
    logic        exc_in_delay = 1'b0;
    logic [31:0] exc_pc = '0;
    logic        exc_isa = 1'b0;
    logic        eret = 1'b0;
    logic        csr_we = 1'b0;
    logic [2:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        redirect;
    logic [31:0] redirect_pc;
    logic        isa_mode_out;
    logic        ll_clear;

    int checks = 0;
    int fails = 0;

    logic [31:0] m_st, m_ca, m_epc, m_errpc, m_eb;
    logic        e_red, e_isa, e_ll;
    logic [31:0] e_pc;

    always #4 clk = ~clk;

    exc_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .fpu_req(fpu_req), .exc_in_delay(exc_in_delay), .exc_pc(exc_pc),
        .exc_isa(exc_isa), .eret(eret), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .redirect(redirect),
        .redirect_pc(redirect_pc), .isa_mode_out(isa_mode_out), .ll_clear(ll_clear)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] vec_of(input logic [4:0] code);
        logic [31:0] base;
        base = m_st[22] ? 32'hBFC00200 : m_eb;
        if (!m_st[1] && (code == 5'd2 || code == 5'd3)) return base;
        if (!m_st[1] && code == 5'd0 && m_ca[23]) return base + 32'h200;
        return base + 32'h180;
    endfunction

    task automatic read_all(input string req);
        logic [31:0] exp_v [5];
        exp_v[0] = m_st; exp_v[1] = m_ca; exp_v[2] = m_epc;
        exp_v[3] = m_errpc; exp_v[4] = m_eb;
        for (int s = 0; s < 5; s++) begin
            csr_sel = 3'(s);
            #1;
            chk(req, csr_rdata, exp_v[s]);
        end
    endtask

    task automatic do_op(input bit e, input bit f, input logic [4:0] c, input bit d,
                         input logic [31:0] p, input bit i, input bit r,
                         input bit w, input logic [2:0] s, input logic [31:0] wd,
                         input string req);
        logic [4:0]  code;
        logic [31:0] t;
        @(negedge clk);
        exc_req = e; fpu_req = f; exc_code = c; exc_in_delay = d;
        exc_pc = p; exc_isa = i; eret = r; csr_we = w; csr_sel = s; csr_wdata = wd;
        e_red = 1'b0; e_ll = 1'b0;
        if (e || f) begin
            code = e ? c : 5'd11;
            e_pc = vec_of(code);
            if (!m_st[1]) begin
                m_epc = p | {31'b0, i};
                m_ca[31] = d;
            end
            if (f && !e) m_ca[28] = 1'b1;
            m_ca[6:2] = code;
            m_st[1] = 1'b1;
            m_st[2] = 1'b0;
            e_red = 1'b1; e_isa = 1'b0;
        end else if (r) begin
            if (m_st[2]) begin t = m_errpc; m_st[2] = 1'b0; end
            else begin t = m_epc; m_st[1] = 1'b0; end
            e_red = 1'b1; e_ll = 1'b1; e_isa = t[0];
            e_pc = {t[31:1], 1'b0};
        end else if (w) begin
            case (s)
                3'd0: m_st = wd;
                3'd1: m_ca = wd;
                3'd2: m_epc = wd;
                3'd3: m_errpc = wd;
                3'd4: m_eb = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        exc_req = 0; fpu_req = 0; eret = 0; csr_we = 0;
        chk({req, " redirect R10"}, {31'b0, redirect}, {31'b0, e_red});
        chk({req, " ll_clear R8"}, {31'b0, ll_clear}, {31'b0, e_ll});
        chk({req, " isa R5/R8"}, {31'b0, isa_mode_out}, {31'b0, e_isa});
        if (e_red) chk({req, " target R6/R7/R8"}, redirect_pc, e_pc);
        read_all({req, " regs"});
        @(negedge clk);
        chk({req, " pulse width R10"}, {31'b0, redirect}, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_st = 32'h00400000; m_ca = 0; m_epc = 0; m_errpc = 0; m_eb = 32'h80000000;
        e_red = 0; e_isa = 0; e_ll = 0; e_pc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 redirect", {31'b0, redirect}, 0);
        chk("R1 ll_clear", {31'b0, ll_clear}, 0);
        chk("R1 isa", {31'b0, isa_mode_out}, 0);
        read_all("R1 reset regs");
        // R6 boot base general vector, R2 EPC with isa flag, delay slot
        do_op(1, 0, 5'd8, 1, 32'h00001000, 1, 0, 0, 0, 0, "R2 R6 boot syscall");
        // R3 nested: EPC and BD held, no offset (R7)
        do_op(1, 0, 5'd2, 0, 32'h00002000, 0, 0, 0, 0, 0, "R3 R7 nested tlb");
        // R8 return via EPC with odd address
        do_op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 eret epc");
        // R11 switch to programmable base
        do_op(0, 0, 0, 0, 0, 0, 0, 1, 3'd4, 32'h9000_0000, "R11 write ebase");
        do_op(0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 32'h0000_0000, "R11 write status");
        // R7 TLB offset 0 when not nested
        do_op(1, 0, 5'd3, 0, 32'h0000_3000, 0, 0, 0, 0, 0, "R7 tlb store");
        do_op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 eret back");
        // R7 interrupt with IV set
        do_op(0, 0, 0, 0, 0, 0, 0, 1, 3'd1, 32'h0080_0000, "R11 write cause iv");
        do_op(1, 0, 5'd0, 0, 32'h0000_4000, 0, 0, 0, 0, 0, "R7 irq iv");
        // R7 interrupt while nested: general offset
        do_op(1, 0, 5'd0, 1, 32'h0000_5000, 1, 0, 0, 0, 0, "R7 irq nested");
        // R8 ERL priority
        do_op(0, 0, 0, 0, 0, 0, 0, 1, 3'd3, 32'h0000_7001, "R11 write errpc");
        do_op(0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 32'h0000_0006, "R11 status erl exl");
        do_op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 eret erl");
        do_op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 eret exl");
        // R9 missing FPU
        do_op(0, 1, 5'd4, 1, 32'h0000_8000, 0, 0, 0, 0, 0, "R9 fpu");
        // R10 exception beats eret and fpu; R11 write dropped
        do_op(1, 1, 5'd12, 0, 32'h0000_9000, 0, 1, 1, 3'd4, 32'h1234_5678, "R10 R11 exc+eret+write");
        do_op(0, 0, 0, 0, 0, 0, 1, 1, 3'd2, 32'hDEAD_BEEF, "R11 eret+write");
        // R11 unmapped select reads 0
        csr_sel = 3'd6; #1; chk("R11 sel6", csr_rdata, 0);
        csr_sel = 3'd7; #1; chk("R11 sel7", csr_rdata, 0);
        // Random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [4:0] codes [11];
            logic [4:0] rc;
            codes = '{5'd0, 5'd2, 5'd3, 5'd4, 5'd5, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13};
            rc = codes[$urandom % 11];
            op = $urandom % 8;
            case (op)
                0, 1, 2: do_op(1, 0, rc, 1'($urandom), $urandom, 1'($urandom), 0, 0, 0, 0, "R2 R4 R6 rnd exc");
                3: do_op(0, 1, rc, 1'($urandom), $urandom, 1'($urandom), 0, 0, 0, 0, "R9 rnd fpu");
                4: do_op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 rnd eret");
                5: do_op(0, 0, 0, 0, 0, 0, 0, 1, 3'($urandom % 5),
                         $urandom & 32'hFFFF_FF87 | ($urandom % 2 ? 32'h0040_0000 : 0), "R11 rnd write");
                6: do_op(1, 1'($urandom), rc, 1'($urandom), $urandom, 1'($urandom), 1, 0, 0, 0, "R10 rnd exc+eret");
                default: do_op(1, 0, rc, 1'($urandom), $urandom, 1'($urandom), 0, 1, 3'($urandom % 5), $urandom, "R11 rnd exc+write");
            endcase
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule